// File: doc/BRIEF.md
# Packed Quad-Byte Video ALU

This block is a SIMD arithmetic unit for pixel data. Each of its two 32-bit operands carries four unsigned 8-bit picture elements, and a 3-bit opcode selects one lane-wise operation on them. The available operations are:

- wrapping byte add;
- wrapping byte subtract;
- rounded byte mean;
- a variant of the mean that writes its results on 16-bit boundaries;
- a dual saturating add, which adds unsigned bytes to signed 16-bit values and clamps each sum to the byte range.

The result is held in a register and appears one clock after the operation is issued.

A datapath issues one operation per cycle by raising `op_valid`. The outputs are:

- `res_valid`, which marks the cycle in which `res` carries that operation's result;
- `res`, which keeps its last value while no operation is issued.

Typical uses are frame differencing, blending and motion compensation, where a signed correction term is added to a reference pixel.

Top module: `pbv_alu`

## Requirements
- R1: Opcode 0 adds the four byte lanes of `src_a` and `src_b` modulo 256. No carry passes from one lane into the next.
- R2: Opcode 1 subtracts each byte lane of `src_b` from the same lane of `src_a` modulo 256. No borrow passes between lanes.
- R3: Opcode 2 gives, in each of the four byte lanes, (a+b+1)>>1 evaluated without overflow, so that halves round up.
- R4: Opcode 3 forms the rounded mean of byte lanes 0 and 2 only and places them at res[7:0] and res[23:16]. Bits [15:8] and [31:24] are zero.
- R5: Opcode 4 reads `src_a[15:0]` and `src_a[31:16]` as signed 16-bit values. It adds the unsigned bytes `src_b[7:0]` and `src_b[23:16]` to them respectively and clamps each sum: below 0 gives 0, above 255 gives 255. The results go to res[7:0] and res[23:16], and the other bits are zero.
- R6: Opcodes 5, 6 and 7 produce an all-zero result.
- R7: `res` and `res_valid` take their new values on the first rising clock edge after the operation is presented. `res_valid` equals the `op_valid` of the previous cycle.
- R8: While `op_valid` is low, `res` keeps its previous value whatever the operands and opcode are.
- R9: After reset, `res` and `res_valid` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Issue an operation this cycle |
| op | input | 3 | Operation select (0 add, 1 sub, 2 mean, 3 half-word mean, 4 saturating add) |
| src_a | input | 32 | First operand: four bytes, or two signed halfwords for opcode 4 |
| src_b | input | 32 | Second operand: four unsigned bytes |
| res_valid | output | 1 | Result valid, one cycle after issue |
| res | output | 32 | Registered result |

## Verification
The bench builds the block with its default values: 8-bit lanes and four lanes. At that size, exhaustive corner values per lane are affordable, such as 0x00, 0x01, 0x7F, 0x80 and 0xFF.

Directed vectors drive each carry and borrow boundary. They also drive the rounding of odd sums, both clamp limits (including -32768 and -1), and the reserved opcodes. Idle cycles with changing operands probe the hold behaviour. A randomised stream then mixes all eight opcodes against a behavioural integer model.

// File: rtl/pbv_pkg.sv
package pbv_pkg;
  typedef enum logic [2:0] {
    OP_ADD     = 3'd0,
    OP_SUB     = 3'd1,
    OP_AVG     = 3'd2,
    OP_AVGHALF = 3'd3,
    OP_ADDCLIP = 3'd4
  } pbv_op_e;
endpackage

// File: rtl/pbv_lane.sv
// One byte lane: wrapping sum, wrapping difference, rounded mean.
module pbv_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic [W-1:0] diff,
  output logic [W-1:0] mean
);
  function automatic logic [W-1:0] wrap_add(input logic [W-1:0] x, input logic [W-1:0] y);
    return x + y;
  endfunction

  function automatic logic [W-1:0] wrap_sub(input logic [W-1:0] x, input logic [W-1:0] y);
    return x - y;
  endfunction

  // the intermediate is one bit wider than the lane, so the +1 never overflows
  function automatic logic [W-1:0] round_mean(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W:0] t;
    t = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, 1'b1};
    return t[W:1];
  endfunction

  assign sum  = wrap_add(a, b);
  assign diff = wrap_sub(a, b);
  assign mean = round_mean(a, b);
endmodule

// File: rtl/pbv_clip.sv
// Signed halfword plus unsigned byte, clamped to the unsigned byte range.
module pbv_clip #(
  parameter int W = 8
) (
  input  logic [2*W-1:0] base,
  input  logic [W-1:0]   addend,
  output logic [W-1:0]   clipped,
  output logic           under,
  output logic           over
);
  localparam int SW = 2 * W + 1;

  logic [SW-1:0] s;

  assign s     = {base[2*W-1], base} + {{(W+1){1'b0}}, addend};
  assign under = s[SW-1];
  assign over  = ~s[SW-1] & (|s[SW-2:W]);

  always_comb begin
    if (under)     clipped = '0;
    else if (over) clipped = '1;
    else           clipped = s[W-1:0];
  end
endmodule

// File: rtl/pbv_alu.sv
module pbv_alu #(
  parameter int LANE_W = 8,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    op_valid,
  input  logic [2:0]              op,
  input  logic [LANE_W*LANES-1:0] src_a,
  input  logic [LANE_W*LANES-1:0] src_b,
  output logic                    res_valid,
  output logic [LANE_W*LANES-1:0] res
);
  import pbv_pkg::*;

  localparam int DW     = LANE_W * LANES;
  localparam int HW     = 2 * LANE_W;
  localparam int HALVES = LANES / 2;

  logic [DW-1:0]     sum_vec, diff_vec, mean_vec, half_mean_vec, clip_vec, hi_mask;
  logic [HALVES-1:0] clip_under, clip_over;
  logic [DW-1:0]     next_res;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    pbv_lane #(.W(LANE_W)) u_lane (
      .a    (src_a[l*LANE_W +: LANE_W]),
      .b    (src_b[l*LANE_W +: LANE_W]),
      .sum  (sum_vec[l*LANE_W +: LANE_W]),
      .diff (diff_vec[l*LANE_W +: LANE_W]),
      .mean (mean_vec[l*LANE_W +: LANE_W])
    );
  end

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    logic [LANE_W-1:0] clipped;

    pbv_clip #(.W(LANE_W)) u_clip (
      .base    (src_a[h*HW +: HW]),
      .addend  (src_b[2*h*LANE_W +: LANE_W]),
      .clipped (clipped),
      .under   (clip_under[h]),
      .over    (clip_over[h])
    );

    assign clip_vec[h*HW +: HW]      = {{LANE_W{1'b0}}, clipped};
    assign half_mean_vec[h*HW +: HW] = {{LANE_W{1'b0}}, mean_vec[2*h*LANE_W +: LANE_W]};
    assign hi_mask[h*HW +: HW]       = {{LANE_W{1'b1}}, {LANE_W{1'b0}}};
  end

  always_comb begin
    case (op)
      OP_ADD:     next_res = sum_vec;
      OP_SUB:     next_res = diff_vec;
      OP_AVG:     next_res = mean_vec;
      OP_AVGHALF: next_res = half_mean_vec;
      OP_ADDCLIP: next_res = clip_vec;
      default:    next_res = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res       <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= op_valid;
      if (op_valid) res <= next_res;
    end
  end

  // one-cycle latency of the valid flag
  assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> res_valid == $past(op_valid));

  // result register holds while idle
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(res));

  // reserved opcodes give zero
  assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op > 3'd4) |=> res == '0);

  // lane-0 mean lies between its two inputs
  assert_mean_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op == OP_AVG) |=>
      ((res[LANE_W-1:0] >= $past(src_a[LANE_W-1:0])) || (res[LANE_W-1:0] >= $past(src_b[LANE_W-1:0]))) &&
      ((res[LANE_W-1:0] <= $past(src_a[LANE_W-1:0])) || (res[LANE_W-1:0] <= $past(src_b[LANE_W-1:0]))));

  // half-word placement leaves the upper bytes clear
  assert_half_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op == OP_AVGHALF || op == OP_ADDCLIP)) |=> (res & hi_mask) == '0);

  // a negative sum clamps to zero
  assert_clip_under_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op == OP_ADDCLIP && clip_under[0]) |=> res[LANE_W-1:0] == '0);

  // a sum above the byte range clamps to all ones
  assert_clip_over_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op == OP_ADDCLIP && clip_over[0]) |=> res[LANE_W-1:0] == '1);
endmodule

// File: tb/tb_pbv_alu.sv
module tb_pbv_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic        res_valid;
  logic [31:0] res;

  int          vectors = 0;
  int          fails = 0;
  logic [31:0] exp_res = '0;
  logic        exp_valid = 1'b0;
  string       exp_tag = "R9";

  always #5 clk = ~clk;

  pbv_alu dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op),
    .src_a(src_a), .src_b(src_b), .res_valid(res_valid), .res(res)
  );

  function automatic string tag_of(input int o);
    case (o)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      default: return "R6";
    endcase
  endfunction

  // behavioural model on integers
  function automatic logic [31:0] model(input int o, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] r;
    r = '0;
    for (int k = 0; k < 4; k++) begin
      int x, y, v;
      x = int'((a >> (8*k)) & 32'hFF);
      y = int'((b >> (8*k)) & 32'hFF);
      v = 0;
      case (o)
        0: v = (x + y) % 256;
        1: v = (x - y + 256) % 256;
        2: v = (x + y + 1) / 2;
        3: v = (k % 2 == 0) ? (x + y + 1) / 2 : 0;
        4: begin
          if (k % 2 == 0) begin
            int hv;
            hv = int'((a >> (8*k)) & 32'hFFFF);
            if (hv >= 32768) hv = hv - 65536;
            v = hv + y;
            if (v < 0) v = 0;
            if (v > 255) v = 255;
          end
        end
        default: v = 0;
      endcase
      r = r | (32'(v) << (8*k));
    end
    return r;
  endfunction

  task automatic compare();
    vectors++;
    if (res !== exp_res || res_valid !== exp_valid) begin
      fails++;
      $display("FAIL %s: res=%h valid=%b expected res=%h valid=%b",
               exp_tag, res, res_valid, exp_res, exp_valid);
    end
  endtask

  // compare the previous cycle's result, then drive the next stimulus
  task automatic step(input logic v, input int o, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    compare();
    op_valid = v;
    op = 3'(o);
    src_a = a;
    src_b = b;
    exp_valid = v;
    if (v) begin
      exp_res = model(o, a, b);
      exp_tag = tag_of(o);
    end else begin
      exp_tag = "R8";
    end
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    compare();                      // R9: reset values
    rst_n = 1'b1;

    // R1: wrap per lane, no carry into the neighbour
    step(1, 0, 32'hFF01_80FF, 32'h01FF_8001);
    step(1, 0, 32'h7F7F_7F7F, 32'h0101_0101);
    // R2: borrow stays inside the lane
    step(1, 1, 32'h0001_8000, 32'h0100_0101);
    step(1, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    // R3: round half up, no overflow at 255+255
    step(1, 2, 32'hFF00_0103, 32'hFF01_0104);
    step(1, 2, 32'h8000_FF7F, 32'h7F01_FF80);
    // R4: even lanes only, upper bytes zero
    step(1, 3, 32'hFF11_0322, 32'hFF33_0444);
    // R5: clamp below, inside and above
    step(1, 4, 32'h8000_FFFF, 32'h0000_0001);  // -32768 -> 0, -1+1 -> 0
    step(1, 4, 32'h00FF_0064, 32'h0001_0010);  // 256 -> 255, 116
    step(1, 4, 32'hFFFE_7FFF, 32'hAA01_BBFF);  // -1 -> 0, big -> 255
    step(1, 4, 32'hFF00_0000, 32'h00FF_00FF);  // -256+255 -> 0, 255
    // R6: reserved opcodes
    step(1, 5, 32'h1234_5678, 32'h9ABC_DEF0);
    step(1, 6, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    step(1, 7, 32'h0101_0101, 32'h0101_0101);
    // R8: idle cycles with moving operands leave res untouched
    step(1, 0, 32'h1111_1111, 32'h2222_2222);
    step(0, 0, 32'hFFFF_FFFF, 32'h0000_0001);
    step(0, 4, 32'h0000_00FF, 32'h0000_00FF);
    // R7: back-to-back issue, every cycle compared
    for (int i = 0; i < 2000; i++) begin
      logic v;
      v = ($urandom % 5) != 0;
      step(v, int'($urandom % 8), $urandom, $urandom);
    end
    step(0, 0, '0, '0);
    @(negedge clk);
    compare();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule